// File: doc/BRIEF.md
# Split-Access 64-bit Performance Counters

This block keeps two 64-bit event counters for a core whose control-register path is 32 bits wide. One counter advances on every clock, the other on every clock in which the core reports a retired instruction. Each counter appears as a pair of 32-bit windows, one for the low half and one for the high half. A second, read-only pair of aliases lets less privileged code observe the same values. A free-running external 64-bit timer is passed through to a further read-only window pair.

A small inhibit register freezes either counter independently. Software may load either half of either counter. Such a load replaces that cycle's automatic increment. The 64-bit add completes within one cycle, so a carry out of the low half has already reached the high half by the next read. A write aimed at any read-only alias window is refused: the block flags it and changes no state.

Top module: `perf_counter_bank`

## Requirements
- R1: While reset is asserted and after its release, the cycle counter, the retire counter and the inhibit register are zero, so addresses 0xB00, 0xB02 and 0x320 read 0.
- R2: With inhibit bit 0 clear, the cycle counter increases by one on every clock edge. Its low half reads at 0xB00 and its high half at 0xB80, and the aliases 0xC00 and 0xC80 return the same halves.
- R3: With inhibit bit 2 clear, the retire counter increases by one on each clock edge at which `retired` is high. Its low half reads at 0xB02 and its high half at 0xB82, with aliases at 0xC02 and 0xC82.
- R4: The inhibit register at 0x320 keeps only bit 0 (cycle stop) and bit 2 (retire stop) and reads every other bit as zero. A value written to it governs counting from the following clock edge.
- R5: A write to 0xB00 or 0xB80 loads that 32-bit half of the cycle counter and leaves the other half unchanged. No increment applies at that edge, so the next read returns the written value.
- R6: A write to 0xB02 or 0xB82 loads that half of the retire counter, keeps the other half, and cancels the increment that a simultaneous `retired` pulse would have caused.
- R7: Addresses 0xC01 and 0xC81 return the low and high halves of `timer_val` in the same cycle.
- R8: A write to any address whose upper four bits are 0xC raises `csr_err` combinationally in that cycle and changes no counter or inhibit state.
- R9: When an increment carries out of the low half, the high half has advanced by one by the next read of the pair.
- R10: Any address not listed above reads as zero. A write to such an address is ignored and does not raise `csr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register address for read and write |
| csr_we | input | 1 | Write strobe for the current cycle |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data for `csr_addr` |
| csr_err | output | 1 | Write to a read-only window refused |
| retired | input | 1 | One instruction retired this cycle |
| timer_val | input | 64 | External timer value |

## Verification
The hardest situations to reach are a carry out of the low half while the counter is running freely, and a load that lands in the same cycle as a retire pulse. Both depend on hitting one exact clock edge. The stimulus loads near-overflow values while both counters are frozen by the inhibit register. It then clears the inhibit bits with a write whose effect starts one edge later, so the bench knows the counter value at every following edge. It reads both halves between the same two edges to catch a torn carry, and it pulses `retired` together with a load to show the increment is cancelled.

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int CNT_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [11:0]          csr_addr,
  input  logic                 csr_we,
  input  logic [CNT_W/2-1:0]   csr_wdata,
  output logic [CNT_W/2-1:0]   csr_rdata,
  output logic                 csr_err,
  input  logic                 retired,
  input  logic [CNT_W-1:0]     timer_val
);
  localparam int HALF = CNT_W / 2;

  localparam logic [11:0] A_CYC_LO = 12'hB00;
  localparam logic [11:0] A_CYC_HI = 12'hB80;
  localparam logic [11:0] A_RET_LO = 12'hB02;
  localparam logic [11:0] A_RET_HI = 12'hB82;
  localparam logic [11:0] U_CYC_LO = 12'hC00;
  localparam logic [11:0] U_CYC_HI = 12'hC80;
  localparam logic [11:0] U_TMR_LO = 12'hC01;
  localparam logic [11:0] U_TMR_HI = 12'hC81;
  localparam logic [11:0] U_RET_LO = 12'hC02;
  localparam logic [11:0] U_RET_HI = 12'hC82;
  localparam logic [11:0] A_INHIB  = 12'h320;

  logic [CNT_W-1:0] cyc_q, ret_q;
  logic             stop_cyc_q, stop_ret_q;

  wire ro_window = csr_addr[11:8] == 4'hC;
  assign csr_err = csr_we && ro_window;

  wire wr_cyc_lo = csr_we && csr_addr == A_CYC_LO;
  wire wr_cyc_hi = csr_we && csr_addr == A_CYC_HI;
  wire wr_ret_lo = csr_we && csr_addr == A_RET_LO;
  wire wr_ret_hi = csr_we && csr_addr == A_RET_HI;
  wire wr_inhib  = csr_we && csr_addr == A_INHIB;
  wire wr_cyc    = wr_cyc_lo || wr_cyc_hi;
  wire wr_ret    = wr_ret_lo || wr_ret_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q      <= '0;
      ret_q      <= '0;
      stop_cyc_q <= 1'b0;
      stop_ret_q <= 1'b0;
    end else begin
      if (wr_cyc_lo)       cyc_q <= {cyc_q[CNT_W-1:HALF], csr_wdata};
      else if (wr_cyc_hi)  cyc_q <= {csr_wdata, cyc_q[HALF-1:0]};
      else if (!stop_cyc_q) cyc_q <= cyc_q + 1'b1;

      if (wr_ret_lo)       ret_q <= {ret_q[CNT_W-1:HALF], csr_wdata};
      else if (wr_ret_hi)  ret_q <= {csr_wdata, ret_q[HALF-1:0]};
      else if (retired && !stop_ret_q) ret_q <= ret_q + 1'b1;

      if (wr_inhib) begin
        stop_cyc_q <= csr_wdata[0];
        stop_ret_q <= csr_wdata[2];
      end
    end
  end

  always_comb begin
    case (csr_addr)
      A_CYC_LO, U_CYC_LO: csr_rdata = cyc_q[HALF-1:0];
      A_CYC_HI, U_CYC_HI: csr_rdata = cyc_q[CNT_W-1:HALF];
      A_RET_LO, U_RET_LO: csr_rdata = ret_q[HALF-1:0];
      A_RET_HI, U_RET_HI: csr_rdata = ret_q[CNT_W-1:HALF];
      U_TMR_LO:           csr_rdata = timer_val[HALF-1:0];
      U_TMR_HI:           csr_rdata = timer_val[CNT_W-1:HALF];
      A_INHIB:            csr_rdata = {{(HALF-3){1'b0}}, stop_ret_q, 1'b0, stop_cyc_q};
      default:            csr_rdata = '0;
    endcase
  end

  assert_ro_write_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    csr_err |=> $stable(stop_cyc_q) && $stable(stop_ret_q));

  assert_cycle_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cyc_q && !wr_cyc) |=> $stable(cyc_q));

  assert_retire_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retired && !stop_ret_q && !wr_ret) |=> ret_q == $past(ret_q) + 1'b1);

  assert_retire_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ret_lo |=> ret_q[HALF-1:0] == $past(csr_wdata) && ret_q[CNT_W-1:HALF] == $past(ret_q[CNT_W-1:HALF]));

  assert_cycle_high_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc_hi |=> cyc_q[HALF-1:0] == $past(cyc_q[HALF-1:0]));

  assert_low_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_cyc_q && !wr_cyc && &cyc_q[HALF-1:0]) |=>
      cyc_q[HALF-1:0] == '0 && cyc_q[CNT_W-1:HALF] == $past(cyc_q[CNT_W-1:HALF]) + 1'b1);
endmodule

// File: tb/perf_counter_bank_tb.sv
module perf_counter_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_err;
  logic        retired = 1'b0;
  logic [63:0] timer_val = 64'hDEADBEEF_0BADF00D;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  perf_counter_bank dut_i (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_err(csr_err),
    .retired(retired), .timer_val(timer_val)
  );

  // {req[3:0], addr[11:0], we, ret, chk, err, wdata[31:0], exp[31:0]}
  localparam int NV = 21;
  localparam logic [83:0] VEC [NV] = '{
    {4'd1,  12'h320, 1'b1, 1'b0, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000000}, // R1 inhibit zero
    {4'd4,  12'h320, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h00000005}, // R4 only bits 0,2
    {4'd5,  12'hB00, 1'b1, 1'b0, 1'b0, 1'b0, 32'h11112222, 32'h0},        // R5
    {4'd5,  12'hB80, 1'b1, 1'b0, 1'b0, 1'b0, 32'h33334444, 32'h0},        // R5
    {4'd5,  12'hB00, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h11112222}, // R5
    {4'd5,  12'hB80, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h33334444}, // R5
    {4'd5,  12'hB00, 1'b1, 1'b0, 1'b1, 1'b0, 32'hAAAAAAAA, 32'h11112222}, // R5
    {4'd5,  12'hB80, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h33334444}, // R5 other half kept
    {4'd2,  12'hC00, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'hAAAAAAAA}, // R2 alias
    {4'd6,  12'hB02, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000FFFF, 32'h0},        // R6
    {4'd6,  12'hB82, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00000007, 32'h0},        // R6
    {4'd3,  12'hC02, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h0000FFFF}, // R3 alias
    {4'd3,  12'hC82, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h00000007}, // R3 alias
    {4'd8,  12'hC00, 1'b1, 1'b0, 1'b1, 1'b1, 32'h12345678, 32'hAAAAAAAA}, // R8
    {4'd8,  12'hB00, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'hAAAAAAAA}, // R8 unchanged
    {4'd7,  12'hC01, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h0BADF00D}, // R7
    {4'd7,  12'hC81, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'hDEADBEEF}, // R7
    {4'd8,  12'hC81, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0,        32'hDEADBEEF}, // R8 timer write
    {4'd10, 12'h7C0, 1'b1, 1'b0, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h0},        // R10
    {4'd10, 12'h7C0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h0},        // R10
    {4'd4,  12'h320, 1'b1, 1'b0, 1'b1, 1'b0, 32'h00000001, 32'h00000005}  // R4
  };

  task automatic cyc(input logic [11:0] a, input logic we, input logic [31:0] wd, input logic r);
    @(negedge clk);
    csr_addr = a; csr_we = we; csr_wdata = wd; retired = r;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    csr_addr = a;
    #1;
    checks++;
    if (csr_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %h: actual %h expected %h", req, a, csr_rdata, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(12'hB00, 32'h0, "R1");
    rd(12'hB02, 32'h0, "R1");
    rd(12'h320, 32'h0, "R1");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [83:0] v;
      v = VEC[i];
      cyc(v[79:68], v[67], v[63:32], v[66]);
      #1;
      checks++;
      if (csr_err !== v[64]) begin
        fails++;
        $display("FAIL R%0d vec %0d err: actual %b expected %b", v[83:80], i, csr_err, v[64]);
      end
      if (v[65]) begin
        checks++;
        if (csr_rdata !== v[31:0]) begin
          fails++;
          $display("FAIL R%0d vec %0d: actual %h expected %h", v[83:80], i, csr_rdata, v[31:0]);
        end
      end
    end

    // inhibit = 1: cycle frozen, retire enabled
    cyc(12'hB00, 1'b1, 32'hFFFFFFFE, 1'b0);
    cyc(12'h320, 1'b1, 32'h0, 1'b0);
    cyc(12'hB00, 1'b0, 32'h0, 1'b0);
    rd(12'hB00, 32'hFFFFFFFE, "R4");
    cyc(12'hB00, 1'b0, 32'h0, 1'b0);
    rd(12'hB00, 32'hFFFFFFFF, "R2");
    cyc(12'hB00, 1'b0, 32'h0, 1'b0);
    rd(12'hB00, 32'h0, "R9");
    rd(12'hB80, 32'h33334445, "R9");
    cyc(12'hB00, 1'b0, 32'h0, 1'b0);
    rd(12'hB00, 32'h1, "R2");
    cyc(12'hB80, 1'b1, 32'h55, 1'b0);
    cyc(12'hB00, 1'b0, 32'h0, 1'b0);
    rd(12'hB00, 32'h2, "R5");
    rd(12'hB80, 32'h55, "R5");
    cyc(12'hB00, 1'b1, 32'h100, 1'b0);
    cyc(12'hB00, 1'b0, 32'h0, 1'b0);
    rd(12'hB00, 32'h100, "R5");

    repeat (3) cyc(12'hC02, 1'b0, 32'h0, 1'b1);
    cyc(12'hC02, 1'b0, 32'h0, 1'b0);
    rd(12'hC02, 32'h00010002, "R3");
    rd(12'hC82, 32'h7, "R3");

    cyc(12'hB02, 1'b1, 32'h100, 1'b1);
    cyc(12'hB02, 1'b0, 32'h0, 1'b0);
    rd(12'hB02, 32'h100, "R6");
    rd(12'hB82, 32'h7, "R6");

    cyc(12'hB02, 1'b1, 32'hFFFFFFFF, 1'b0);
    cyc(12'hB02, 1'b0, 32'h0, 1'b1);
    rd(12'hB02, 32'hFFFFFFFF, "R9");
    cyc(12'hB02, 1'b0, 32'h0, 1'b0);
    rd(12'hB02, 32'h0, "R9");
    rd(12'hB82, 32'h8, "R9");

    cyc(12'hB82, 1'b1, 32'h9, 1'b1);
    cyc(12'hB82, 1'b0, 32'h0, 1'b0);
    rd(12'hB82, 32'h9, "R6");
    rd(12'hB02, 32'h0, "R6");

    cyc(12'h320, 1'b1, 32'h4, 1'b0);
    cyc(12'hB02, 1'b0, 32'h0, 1'b1);
    cyc(12'hB02, 1'b0, 32'h0, 1'b1);
    cyc(12'hB02, 1'b0, 32'h0, 1'b0);
    rd(12'hB02, 32'h0, "R4");
    rd(12'h320, 32'h4, "R4");

    cyc(12'hC82, 1'b1, 32'hFFFF, 1'b0);
    cyc(12'hB82, 1'b0, 32'h0, 1'b0);
    rd(12'hB82, 32'h9, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule